// File: doc/BRIEF.md
# I2C-controlled 8-bit I/O expander

This block is an I2C target that lets a host read and drive a small general-purpose port through four addressed byte registers: a live view of the input pins, an output latch, a per-pin polarity inverter and a per-pin direction selector. A command (pointer) register picks which of the four registers a following data byte or read reaches. SCL and SDA are sampled on a faster system clock through a synchronizer. START, repeated START and STOP are detected from the synchronized lines. The block pulls SDA low through an open-drain enable and never drives it high.

The 7-bit bus address is a fixed four-bit prefix followed by three strap pins. A host writes a register by sending the address, a command byte and a data byte. It reads one by sending the command, then a repeated START with the read bit. A bare read with no command returns whichever register was selected last, because the pointer survives between transactions. Reads of the input register continue for as long as the host acknowledges, and the pins are sampled again for every byte.

Top module: `i2c_gpio_expander`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {ADDR_HI (default 4'b0011), addr_pins}; bit 0 of that byte is 0 for write and 1 for read. On a mismatch SDA stays released and the block ignores the bus until the next START.
- R2: During the ninth SCL pulse after a matched address byte, and after every command and data byte of a write, the block holds sda_oe high for the whole SCL-high time.
- R3: The two low command bits select the target: 0 input, 1 output, 2 polarity, 3 direction; the upper six bits are ignored. A data byte sent to selector 0 is acknowledged but changes no register.
- R4: port_out equals the output register. A new output byte appears on port_out after its eighth data bit and before the rising SCL edge of its acknowledge pulse, and not earlier.
- R5: port_oe bit i is 1 exactly when direction bit i is 0; a direction bit of 1 makes the pin an input.
- R6: A read of selector 0 returns port_in XOR polarity register; reads of selectors 1 to 3 return the stored register.
- R7: A read with no command byte returns the register selected by the most recently written command byte, across any number of transactions.
- R8: While the host acknowledges read bytes, the block keeps sending bytes, and each new byte of the input register reflects port_in as sampled at the end of the previous acknowledge.
- R9: After a host NACK on a read byte the block releases SDA and keeps it released until the next START.
- R10: A STOP at any bit position returns the bus logic to idle with SDA released; registers already written keep their values, and a partly sent read byte is dropped.
- R11: After reset, port_oe is 0, port_out is 0, polarity is 0, the command pointer is 0 and SDA is released.
- R12: The block changes sda_oe only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_pins | input | 3 | Low three address bits |
| port_in | input | PORT_W | Pin input levels |
| port_out | output | PORT_W | Pin output values |
| port_oe | output | PORT_W | Pin driver enables, 1 drives |

## Verification
The bench builds the block with its default parameters: an eight-pin port, a two-stage synchronizer and the 0011 prefix. With three strap pins, every strap combination can be swept against both a matching and a mismatching address. The eight-bit registers are narrow enough that arithmetic value sequences with varying upper command bits reach every selector many times. Polarity and input patterns are swept together and checked against an XOR model. The bench also walks through the bit-level orderings: the exact half-bit in which the output changes, a STOP in the middle of a read byte, and a multi-byte read with a new pin pattern per byte.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ADDR   = 3'd1,
      ST_ACK    = 3'd2,
      ST_WR     = 3'd3,
      ST_RD     = 3'd4,
      ST_RD_ACK = 3'd5
   } gpx_state_t;

   localparam int SEL_BITS = 2;

   typedef enum logic [SEL_BITS-1:0] {
      SEL_IN  = 2'd0,
      SEL_OUT = 2'd1,
      SEL_POL = 2'd2,
      SEL_DIR = 2'd3
   } gpx_sel_t;

endpackage

// File: rtl/gpx_bus_sync.sv
module gpx_bus_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [SYNC_STAGES-1:0] scl_ff;
   logic [SYNC_STAGES-1:0] sda_ff;
   logic                   scl_q;
   logic                   sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
         scl_q  <= scl_ff[SYNC_STAGES-1];
         sda_q  <= sda_ff[SYNC_STAGES-1];
      end
   end

   assign scl_s     = scl_ff[SYNC_STAGES-1];
   assign sda_s     = sda_ff[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/gpx_link.sv
module gpx_link
   import gpx_pkg::*;
#(
   parameter int         PORT_W  = 8,
   parameter logic [3:0] ADDR_HI = 4'b0011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [2:0]        addr_pins,
   input  logic [PORT_W-1:0] rd_data,
   output logic              sda_oe,
   output logic              wr_en,
   output logic              wr_cmd,
   output logic [7:0]        wr_byte
);

   localparam logic [3:0] LAST_BIT = 4'd7;
   localparam logic [3:0] FULL     = 4'd8;

   gpx_state_t st;
   logic [3:0] cnt;
   logic [7:0] rx_sh;
   logic [7:0] tx_sh;
   logic       rnw;
   logic       first;
   logic       mack;
   logic [7:0] rd8;
   logic [6:0] own;

   always_comb begin
      rd8               = '0;
      rd8[PORT_W-1:0]   = rd_data;
   end

   assign own = {ADDR_HI, addr_pins};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         rnw     <= 1'b0;
         first   <= 1'b0;
         mack    <= 1'b0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_cmd  <= 1'b0;
         wr_byte <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            st     <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (st)
               ST_ADDR: begin
                  if (scl_rise) begin
                     rx_sh <= {rx_sh[6:0], sda_s};
                     cnt   <= cnt + 4'd1;
                  end else if (scl_fall && cnt == FULL) begin
                     if (rx_sh[7:1] == own) begin
                        st     <= ST_ACK;
                        sda_oe <= 1'b1;
                        rnw    <= rx_sh[0];
                        first  <= 1'b1;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rnw) begin
                        st     <= ST_RD;
                        tx_sh  <= rd8;
                        sda_oe <= ~rd8[7];
                     end else begin
                        st     <= ST_WR;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_WR: begin
                  if (scl_rise) begin
                     rx_sh <= {rx_sh[6:0], sda_s};
                     cnt   <= cnt + 4'd1;
                  end else if (scl_fall && cnt == FULL) begin
                     wr_en   <= 1'b1;
                     wr_cmd  <= first;
                     wr_byte <= rx_sh;
                     first   <= 1'b0;
                     st      <= ST_ACK;
                     sda_oe  <= 1'b1;
                  end
               end
               ST_RD: begin
                  if (scl_fall) begin
                     if (cnt == LAST_BIT) begin
                        st     <= ST_RD_ACK;
                        sda_oe <= 1'b0;
                     end else begin
                        tx_sh  <= {tx_sh[6:0], 1'b0};
                        sda_oe <= ~tx_sh[6];
                        cnt    <= cnt + 4'd1;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack) begin
                        st     <= ST_RD;
                        cnt    <= '0;
                        tx_sh  <= rd8;
                        sda_oe <= ~rd8[7];
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R12
   sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   // R1
   addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ADDR && scl_fall && !start_det && !stop_det && cnt == FULL
       && rx_sh[7:1] != own) |=> (st == ST_IDLE && !sda_oe));

   // R10
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> (!sda_oe && st == ST_IDLE));

endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
   import gpx_pkg::*;
#(
   parameter int PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_cmd,
   input  logic [7:0]        wr_byte,
   input  logic [PORT_W-1:0] port_in,
   output logic [PORT_W-1:0] rd_data,
   output logic [PORT_W-1:0] port_out,
   output logic [PORT_W-1:0] port_oe
);

   gpx_sel_t          sel;
   logic [PORT_W-1:0] out_q;
   logic [PORT_W-1:0] pol_q;
   logic [PORT_W-1:0] dir_q;
   logic [PORT_W-1:0] in_view;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel   <= SEL_IN;
         out_q <= '0;
         pol_q <= '0;
         dir_q <= '1;
      end else if (wr_en) begin
         if (wr_cmd) begin
            sel <= gpx_sel_t'(wr_byte[SEL_BITS-1:0]);
         end else begin
            unique case (sel)
               SEL_OUT: out_q <= wr_byte[PORT_W-1:0];
               SEL_POL: pol_q <= wr_byte[PORT_W-1:0];
               SEL_DIR: dir_q <= wr_byte[PORT_W-1:0];
               default: ;
            endcase
         end
      end
   end

   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      assign in_view[i] = port_in[i] ^ pol_q[i];
      assign port_oe[i] = ~dir_q[i];
   end

   always_comb begin
      unique case (sel)
         SEL_OUT: rd_data = out_q;
         SEL_POL: rd_data = pol_q;
         SEL_DIR: rd_data = dir_q;
         default: rd_data = in_view;
      endcase
   end

   assign port_out = out_q;

   // R4
   out_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(port_out) |-> $past(wr_en));

   // R3
   in_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_cmd && sel == SEL_IN) |=>
         ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));

endmodule

// File: rtl/i2c_gpio_expander.sv
module i2c_gpio_expander #(
   parameter int         PORT_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] ADDR_HI     = 4'b0011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [2:0]        addr_pins,
   input  logic [PORT_W-1:0] port_in,
   output logic [PORT_W-1:0] port_out,
   output logic [PORT_W-1:0] port_oe
);

   if (PORT_W < 1 || PORT_W > 8) begin : g_bad_width
      $error("PORT_W must lie in 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic              scl_s;
   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              wr_en;
   logic              wr_cmd;
   logic [7:0]        wr_byte;
   logic [PORT_W-1:0] rd_data;

   gpx_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   gpx_link #(.PORT_W(PORT_W), .ADDR_HI(ADDR_HI)) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .addr_pins (addr_pins),
      .rd_data   (rd_data),
      .sda_oe    (sda_oe),
      .wr_en     (wr_en),
      .wr_cmd    (wr_cmd),
      .wr_byte   (wr_byte)
   );

   gpx_regs #(.PORT_W(PORT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_cmd   (wr_cmd),
      .wr_byte  (wr_byte),
      .port_in  (port_in),
      .rd_data  (rd_data),
      .port_out (port_out),
      .port_oe  (port_oe)
   );

   // R11
   reset_idle_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (!sda_oe && port_oe == '0 && port_out == '0));

endmodule

// File: tb/i2c_gpio_expander_tb.sv
module i2c_gpio_expander_tb;

   localparam int Q = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] pins = 3'b101;
   logic [7:0] pin_in = 8'h3C;
   logic       sda_oe;
   logic [7:0] port_out;
   logic [7:0] port_oe;
   wire        sda_line = sda_m & ~sda_oe;

   int total = 0;
   int bad = 0;

   logic [7:0] m_out = 8'h00;
   logic [7:0] m_pol = 8'h00;
   logic [7:0] m_dir = 8'hFF;
   logic [1:0] m_sel = 2'd0;

   always #5 clk = ~clk;

   i2c_gpio_expander u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .addr_pins (pins),
      .port_in   (pin_in),
      .port_out  (port_out),
      .port_oe   (port_oe)
   );

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input logic [1:0] s);
      case (s)
         2'd0:    return pin_in ^ m_pol;
         2'd1:    return m_out;
         2'd2:    return m_pol;
         default: return m_dir;
      endcase
   endfunction

   task automatic i2c_start();
      sda_m = 1'b1; wt(Q);
      scl_m = 1'b1; wt(Q);
      sda_m = 1'b0; wt(Q);
      scl_m = 1'b0; wt(Q);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wt(Q);
      scl_m = 1'b1; wt(Q);
      sda_m = 1'b1; wt(Q);
   endtask

   task automatic put_bit(input logic b);
      sda_m = b;    wt(Q);
      scl_m = 1'b1; wt(2 * Q);
      scl_m = 1'b0; wt(Q);
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; wt(Q);
      scl_m = 1'b1; wt(Q);
      b = sda_line; wt(Q);
      scl_m = 1'b0; wt(Q);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic recv_bits(output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
   endtask

   function automatic logic [7:0] abyte(input logic rd);
      return {4'b0011, pins, rd};
   endfunction

   task automatic wr_reg(input logic [7:0] cmd, input logic [7:0] d);
      logic a;
      i2c_start();
      send_byte(abyte(1'b0), a); chk("R2 addr ack", {7'd0, a}, 8'd1);
      send_byte(cmd, a);         chk("R2 cmd ack", {7'd0, a}, 8'd1);
      send_byte(d, a);           chk("R2 data ack", {7'd0, a}, 8'd1);
      i2c_stop();
      m_sel = cmd[1:0];
      case (cmd[1:0])
         2'd1: m_out = d;
         2'd2: m_pol = d;
         2'd3: m_dir = d;
         default: ;
      endcase
   endtask

   task automatic set_ptr(input logic [7:0] cmd);
      logic a;
      i2c_start();
      send_byte(abyte(1'b0), a);
      send_byte(cmd, a); chk("R7 cmd ack", {7'd0, a}, 8'd1);
      i2c_stop();
      m_sel = cmd[1:0];
   endtask

   task automatic bare_read(output logic [7:0] d);
      logic a;
      i2c_start();
      send_byte(abyte(1'b1), a);
      recv_bits(d);
      put_bit(1'b1);
      i2c_stop();
   endtask

   task automatic rd_reg(input logic [7:0] cmd, output logic [7:0] d);
      logic a;
      i2c_start();
      send_byte(abyte(1'b0), a);
      send_byte(cmd, a);
      i2c_start();
      send_byte(abyte(1'b1), a); chk("R6 read addr ack", {7'd0, a}, 8'd1);
      recv_bits(d);
      put_bit(1'b1);
      i2c_stop();
      m_sel = cmd[1:0];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic       a;
      wt(5);
      // R11 reset values
      chk("R11 port_oe", port_oe, 8'h00);
      chk("R11 port_out", port_out, 8'h00);
      chk("R11 sda_oe", {7'd0, sda_oe}, 8'd0);
      rst_n = 1'b1;
      wt(5);
      bare_read(d);
      chk("R11 pointer", d, pin_in);

      // R1 address sweep over every strap combination
      for (int p = 0; p < 8; p++) begin
         pins = 3'(p);
         i2c_start(); send_byte({4'b0011, 3'(p), 1'b0}, a); i2c_stop();
         chk("R1 match", {7'd0, a}, 8'd1);
         i2c_start(); send_byte({4'b0011, 3'(p) ^ 3'b010, 1'b0}, a); i2c_stop();
         chk("R1 pin miss", {7'd0, a}, 8'd0);
         i2c_start(); send_byte({4'b0111, 3'(p), 1'b0}, a); i2c_stop();
         chk("R1 prefix miss", {7'd0, a}, 8'd0);
      end
      pins = 3'b101;

      // R3 R5 R6 register sweep with noise in upper command bits
      for (int i = 0; i < 12; i++) begin
         logic [7:0] v;
         logic [7:0] c;
         v = 8'(i * 53 + 17);
         c = 8'((i << 2) | (1 + i % 3));
         wr_reg(c, v);
         rd_reg(8'(c & 8'hF3), d);
         chk("R3 readback", d, exp_rd(c[1:0]));
         chk("R4 port_out", port_out, m_out);
         chk("R5 port_oe", port_oe, ~m_dir);
      end

      // R6 input and polarity sweep
      for (int j = 0; j < 8; j++) begin
         wr_reg(8'h02, 8'(j * 71 + 9));
         pin_in = 8'(j * 29 + 7);
         rd_reg(8'h00, d);
         chk("R6 input xor pol", d, pin_in ^ m_pol);
      end

      // R3 write to input selector ignored
      wr_reg(8'hFC, 8'hFF);
      rd_reg(8'h01, d); chk("R3 ignored out", d, m_out);
      rd_reg(8'h02, d); chk("R3 ignored pol", d, m_pol);
      rd_reg(8'h03, d); chk("R3 ignored dir", d, m_dir);
      chk("R3 ignored pins", port_out, m_out);

      // R7 pointer persistence
      set_ptr(8'h02);
      bare_read(d); chk("R7 bare read 1", d, m_pol);
      bare_read(d); chk("R7 bare read 2", d, m_pol);
      rd_reg(8'h03, d);
      bare_read(d); chk("R7 after read", d, m_dir);

      // R8 continuous input read, R9 release after NACK
      set_ptr(8'h00);
      pin_in = 8'h11;
      i2c_start();
      send_byte(abyte(1'b1), a);
      for (int k = 0; k < 5; k++) begin
         recv_bits(d);
         chk("R8 stream byte", d, pin_in ^ m_pol);
         pin_in = 8'(k * 47 + 3);
         put_bit(k == 4);
      end
      wt(Q);
      chk("R9 released", {7'd0, sda_oe}, 8'd0);
      get_bit(a);
      chk("R9 stays released", {7'd0, a}, 8'd1);
      i2c_stop();

      // R4 output timing at the acknowledge
      i2c_start();
      send_byte(abyte(1'b0), a);
      send_byte(8'h01, a);
      for (int i = 7; i >= 1; i--) put_bit(d[0] ^ d[0] ^ 8'h96 >> i);
      chk("R4 not early", port_out, m_out);
      put_bit(1'b0);
      chk("R4 before ack edge", port_out, 8'h96);
      chk("R2 ack low", {7'd0, sda_oe}, 8'd1);
      get_bit(a);
      i2c_stop();
      m_out = 8'h96;
      m_sel = 2'd1;

      // R10 STOP in the middle of a read byte
      wr_reg(8'h01, 8'h5A);
      i2c_start();
      send_byte(abyte(1'b1), a);
      for (int i = 0; i < 4; i++) get_bit(a);
      i2c_stop();
      wt(Q);
      chk("R10 released", {7'd0, sda_oe}, 8'd0);
      chk("R10 output kept", port_out, 8'h5A);
      bare_read(d);
      chk("R10 next read", d, 8'h5A);

      // R11 reset in mid use
      rst_n = 1'b0;
      wt(3);
      chk("R11 port_oe again", port_oe, 8'h00);
      chk("R11 port_out again", port_out, 8'h00);
      rst_n = 1'b1;
      m_pol = 8'h00;
      wt(3);
      bare_read(d);
      chk("R11 pointer and pol", d, pin_in);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule